// File: doc/BRIEF.md
# DMA Transfer Event Generator

This block raises the half-transfer and transfer-complete pulses for one channel of a DMA engine that walks a linked list of descriptors. It does not move data or fetch descriptors. It watches the strobes of the channel sequencer: a data beat with its byte count, the end of a block, the end of a repeated-block set, the finished load of the next descriptor, and the end of a descriptor's whole transfer. From these it decides when each event is due.

A two-bit granularity code selects the unit that events refer to. Code 0 selects a single block. Code 1 selects a whole repeated-block set. Code 2 selects one descriptor. Code 3 selects the whole channel, which means only the last descriptor of the list. When a descriptor starts, the sequencer presents its byte count, its repeat count, whether it is the directly programmed initial transfer, and the link address and update flags loaded with it. The block stores these values together with the granularity code, so a later change on the mode input only takes effect at the next descriptor.

When the `RPT_EN` parameter is cleared, the channel has no repeated-block support and code 1 acts as code 0.

Top module: `dma_evt_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `evt_half_o` and `evt_cplt_o` are both low.
- R2: With granularity 0, every block is its own unit. A complete pulse follows each `blk_done_i`, and a half pulse fires once in each block, also for each block of a repeated set.
- R3: With granularity 1, the unit is the whole repeated-block set, whose size is the byte count times (repeat count + 1). Complete follows `rpt_done_i` only, and `blk_done_i` raises nothing.
- R4: With granularity 2, complete follows `desc_done_i`, and `upd_done_i` raises nothing. Half fires halfway through the descriptor's data, including its repeats, and only if that data is not empty.
- R5: With granularity 3, events are raised only for a descriptor whose link address and update flags were both zero when it started. A zero link with any update flag set does not count as last.
- R6: With granularity 3, descriptors that start with a non-zero link address raise no event, so an endless list stays silent.
- R7: A descriptor marked initial with a zero byte count raises no event under granularity 0 or 1.
- R8: Under granularity 2, such an empty initial descriptor raises no half pulse. Its complete pulse follows `upd_done_i`, and `desc_done_i` is ignored for it.
- R9: The half point of a unit is reached by the first beat after which twice the bytes moved in the unit is at least the unit size. Only one half pulse is raised per unit, including for odd sizes.
- R10: Each event is a one-cycle pulse in the cycle after the strobe that makes it due. If half and complete are due from the same cycle, both pulses appear together.
- R11: The granularity code is taken when `desc_start_i` is high. A change of `mode_i` during a descriptor does not alter that descriptor's events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Event granularity code (0 block, 1 repeated set, 2 descriptor, 3 channel) |
| desc_start_i | input | 1 | A descriptor begins; its fields below are valid |
| desc_bytes_i | input | CNT_W | Block byte count of the starting descriptor |
| desc_rpt_i | input | RPT_W | Extra block repeats of the starting descriptor |
| desc_first_i | input | 1 | Starting descriptor is the directly programmed initial one |
| link_i | input | LINK_W | Next-link address loaded with the starting descriptor |
| uflags_i | input | UFL_W | Update flags loaded with the starting descriptor |
| beat_i | input | 1 | A data beat completed |
| beat_bytes_i | input | BEAT_W | Bytes moved by that beat |
| blk_done_i | input | 1 | A block's byte count reached zero |
| rpt_done_i | input | 1 | The last block of a repeated set finished |
| upd_done_i | input | 1 | Loading of the next descriptor finished |
| desc_done_i | input | 1 | Descriptor transfer, including any update, finished |
| evt_half_o | output | 1 | Half-transfer pulse |
| evt_cplt_o | output | 1 | Transfer-complete pulse |

## Verification
The half-transfer and transfer-complete decisions can fall in the same cycle. This happens when the beat that crosses the halfway point also ends the unit. The bench forces it with a one-byte block, whose single beat arrives together with `blk_done_i`. The scoreboard entry for that cycle expects both bits high together, and any cycle without an entry must show both outputs low. Odd sizes and repeated sets check that the half decision still fires once, and at the correct beat, when it does not coincide with the end of the unit.

// File: rtl/dma_evt_pkg.sv
// Shared types of the DMA event generator.
package dma_evt_pkg;

    // Event granularity; the encoding matches the mode input code.
    typedef enum logic [1:0] {
        GRAN_BLOCK  = 2'd0,
        GRAN_REPEAT = 2'd1,
        GRAN_DESC   = 2'd2,
        GRAN_CHAN   = 2'd3
    } gran_e;

    // Per-descriptor context captured at descriptor start.
    typedef struct packed {
        gran_e gran;
        logic  empty_first;
        logic  last;
    } ctx_t;

endpackage

// File: rtl/dma_evt_ctx.sv
// Descriptor context register.
// Captures the granularity, the byte and repeat counts, the empty-initial
// flag and the last-descriptor flag when a descriptor starts.
// Assumes desc_start_i is a one-cycle strobe with valid fields beside it.
// Without repeat support, code 1 is folded onto block granularity and the
// repeat count is forced to zero.
module dma_evt_ctx
    import dma_evt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int RPT_W  = 11,
    parameter int LINK_W = 14,
    parameter int UFL_W  = 8,
    parameter bit RPT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_start_i,
    input  logic [1:0]        mode_i,
    input  logic [CNT_W-1:0]  desc_bytes_i,
    input  logic [RPT_W-1:0]  desc_rpt_i,
    input  logic              desc_first_i,
    input  logic [LINK_W-1:0] link_i,
    input  logic [UFL_W-1:0]  uflags_i,
    output ctx_t              ctx_o,
    output logic [CNT_W-1:0]  bytes_o,
    output logic [RPT_W-1:0]  rpt_o
);

    gran_e            gran_eff;
    logic [RPT_W-1:0] rpt_eff;

    generate
        if (RPT_EN) begin : g_rpt
            // Purpose: pass the mode and repeat count through unchanged.
            always_comb begin
                gran_eff = gran_e'(mode_i);
                rpt_eff  = desc_rpt_i;
            end
        end else begin : g_norpt
            // Purpose: fold repeated-set granularity onto block granularity.
            always_comb begin
                gran_eff = (mode_i == 2'd1) ? GRAN_BLOCK : gran_e'(mode_i);
                rpt_eff  = '0;
            end
        end
    endgenerate

    // Purpose: hold the context of the descriptor in flight (R11, R5, R7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_o   <= '{gran: GRAN_BLOCK, empty_first: 1'b0, last: 1'b0};
            bytes_o <= '0;
            rpt_o   <= '0;
        end else if (desc_start_i) begin
            ctx_o.gran        <= gran_eff;
            ctx_o.empty_first <= desc_first_i && (desc_bytes_i == '0);
            ctx_o.last        <= (link_i == '0) && (uflags_i == '0);
            bytes_o           <= desc_bytes_i;
            rpt_o             <= rpt_eff;
        end
    end

endmodule

// File: rtl/dma_evt_half.sv
// Half-point tracker.
// Accumulates the bytes moved in the current unit and flags the beat at
// which twice that sum first reaches the unit size (R9).
// The unit is either one block or the block times (repeats + 1).
// Assumes a beat that ends a unit arrives no later than the unit-clear
// strobe. A beat in the same cycle as the clear still counts toward the
// unit that is ending.
module dma_evt_half #(
    parameter int CNT_W  = 16,
    parameter int RPT_W  = 11,
    parameter int BEAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             beat_i,
    input  logic [BEAT_W-1:0] beat_bytes_i,
    input  logic [CNT_W-1:0] bytes_i,
    input  logic [RPT_W-1:0] rpt_i,
    input  logic             per_block_i,
    output logic             due_o
);

    localparam int TOT_W = CNT_W + RPT_W + 1;
    localparam int ACC_W = TOT_W + 1;

    logic [TOT_W-1:0] bytes_ext;
    logic [TOT_W-1:0] reps_ext;
    logic [TOT_W-1:0] total;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nxt;
    logic             seen_q;

    // Purpose: size of the current unit in bytes.
    always_comb begin
        bytes_ext = {{(TOT_W-CNT_W){1'b0}}, bytes_i};
        reps_ext  = {{(TOT_W-RPT_W){1'b0}}, rpt_i} + {{(TOT_W-1){1'b0}}, 1'b1};
        total     = per_block_i ? bytes_ext : (bytes_ext * reps_ext);
    end

    // Purpose: decide whether this beat crosses the half point.
    always_comb begin
        acc_nxt = acc_q + {{(ACC_W-BEAT_W){1'b0}}, beat_bytes_i};
        due_o   = beat_i && !seen_q && (total != '0) &&
                  ({acc_nxt, 1'b0} >= {2'b00, total});
    end

    // Purpose: per-unit byte sum and single-shot flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_q  <= '0;
            seen_q <= 1'b0;
        end else if (beat_i) begin
            acc_q <= acc_nxt;
            if (due_o) begin
                seen_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_evt_cplt.sv
// Completion and unit-boundary decoder.
// From the stored context and the sequencer strobes it finds: whether a
// complete event is due, whether half events are allowed, where the
// half-point unit restarts, and whether that unit is a single block.
// Purely combinational.
module dma_evt_cplt
    import dma_evt_pkg::*;
(
    input  ctx_t ctx_i,
    input  logic desc_start_i,
    input  logic blk_done_i,
    input  logic rpt_done_i,
    input  logic upd_done_i,
    input  logic desc_done_i,
    output logic cplt_due_o,
    output logic half_en_o,
    output logic unit_clr_o,
    output logic per_block_o
);

    // Purpose: per-granularity event rules (R2 to R8).
    always_comb begin
        cplt_due_o  = 1'b0;
        half_en_o   = 1'b1;
        unit_clr_o  = desc_start_i;
        per_block_o = 1'b0;
        case (ctx_i.gran)
            GRAN_BLOCK: begin
                cplt_due_o  = blk_done_i && !ctx_i.empty_first;
                unit_clr_o  = desc_start_i || blk_done_i;
                per_block_o = 1'b1;
            end
            GRAN_REPEAT: begin
                cplt_due_o = rpt_done_i && !ctx_i.empty_first;
                unit_clr_o = desc_start_i || rpt_done_i;
            end
            GRAN_DESC: begin
                cplt_due_o = ctx_i.empty_first ? upd_done_i : desc_done_i;
                unit_clr_o = desc_start_i || desc_done_i;
            end
            GRAN_CHAN: begin
                cplt_due_o = desc_done_i && ctx_i.last && !ctx_i.empty_first;
                half_en_o  = ctx_i.last;
                unit_clr_o = desc_start_i || desc_done_i;
            end
            default: begin
                cplt_due_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dma_evt_gen.sv
// DMA transfer event generator, top level.
// Combines the descriptor context, the half-point tracker and the
// completion decoder, and registers both events as one-cycle pulses that
// appear in the cycle after the strobe that makes them due (R10).
// Assumes the sequencer strobes for a descriptor come after its start.
module dma_evt_gen
    import dma_evt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int RPT_W  = 11,
    parameter int LINK_W = 14,
    parameter int UFL_W  = 8,
    parameter int BEAT_W = 8,
    parameter bit RPT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              desc_start_i,
    input  logic [CNT_W-1:0]  desc_bytes_i,
    input  logic [RPT_W-1:0]  desc_rpt_i,
    input  logic              desc_first_i,
    input  logic [LINK_W-1:0] link_i,
    input  logic [UFL_W-1:0]  uflags_i,
    input  logic              beat_i,
    input  logic [BEAT_W-1:0] beat_bytes_i,
    input  logic              blk_done_i,
    input  logic              rpt_done_i,
    input  logic              upd_done_i,
    input  logic              desc_done_i,
    output logic              evt_half_o,
    output logic              evt_cplt_o
);

    ctx_t             ctx_w;
    logic [CNT_W-1:0] bytes_w;
    logic [RPT_W-1:0] rpt_w;
    logic             cplt_due;
    logic             half_en;
    logic             unit_clr;
    logic             per_block;
    logic             half_raw;

    dma_evt_ctx #(
        .CNT_W(CNT_W), .RPT_W(RPT_W), .LINK_W(LINK_W),
        .UFL_W(UFL_W), .RPT_EN(RPT_EN)
    ) i_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_start_i (desc_start_i),
        .mode_i       (mode_i),
        .desc_bytes_i (desc_bytes_i),
        .desc_rpt_i   (desc_rpt_i),
        .desc_first_i (desc_first_i),
        .link_i       (link_i),
        .uflags_i     (uflags_i),
        .ctx_o        (ctx_w),
        .bytes_o      (bytes_w),
        .rpt_o        (rpt_w)
    );

    dma_evt_cplt i_cplt (
        .ctx_i        (ctx_w),
        .desc_start_i (desc_start_i),
        .blk_done_i   (blk_done_i),
        .rpt_done_i   (rpt_done_i),
        .upd_done_i   (upd_done_i),
        .desc_done_i  (desc_done_i),
        .cplt_due_o   (cplt_due),
        .half_en_o    (half_en),
        .unit_clr_o   (unit_clr),
        .per_block_o  (per_block)
    );

    dma_evt_half #(
        .CNT_W(CNT_W), .RPT_W(RPT_W), .BEAT_W(BEAT_W)
    ) i_half (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (unit_clr),
        .beat_i       (beat_i),
        .beat_bytes_i (beat_bytes_i),
        .bytes_i      (bytes_w),
        .rpt_i        (rpt_w),
        .per_block_i  (per_block),
        .due_o        (half_raw)
    );

    // Purpose: register the event pulses (R1, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_half_o <= 1'b0;
            evt_cplt_o <= 1'b0;
        end else begin
            evt_half_o <= half_raw && half_en;
            evt_cplt_o <= cplt_due;
        end
    end

endmodule

// File: rtl/dma_evt_gen_chk.sv
// Property checker for the DMA transfer event generator, bound to the top.
module dma_evt_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       beat_i,
    input logic       blk_done_i,
    input logic       rpt_done_i,
    input logic       upd_done_i,
    input logic       desc_done_i,
    input logic [1:0] gran,
    input logic       ctx_empty,
    input logic       ctx_last,
    input logic       evt_half_o,
    input logic       evt_cplt_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!evt_half_o && !evt_cplt_o));

    // R10
    cplt_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cplt_o |-> $past(blk_done_i || rpt_done_i || upd_done_i || desc_done_i));

    // R10
    half_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_half_o |-> $past(beat_i));

    // R6
    chan_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gran == 2'd3 && !ctx_last) |=> (!evt_half_o && !evt_cplt_o));

    // R7
    empty_block_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gran[1] == 1'b0 && ctx_empty) |=> (!evt_half_o && !evt_cplt_o));

    // R8
    empty_no_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_empty |=> !evt_half_o);

endmodule

bind dma_evt_gen dma_evt_gen_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_i      (beat_i),
    .blk_done_i  (blk_done_i),
    .rpt_done_i  (rpt_done_i),
    .upd_done_i  (upd_done_i),
    .desc_done_i (desc_done_i),
    .gran        (ctx_w.gran),
    .ctx_empty   (ctx_w.empty_first),
    .ctx_last    (ctx_w.last),
    .evt_half_o  (evt_half_o),
    .evt_cplt_o  (evt_cplt_o)
);

// File: tb/test_dma_evt_gen.sv
// Scoreboard bench: driver tasks queue expected pulses, a monitor compares.
module test_dma_evt_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_i;
    logic        desc_start_i;
    logic [15:0] desc_bytes_i;
    logic [10:0] desc_rpt_i;
    logic        desc_first_i;
    logic [13:0] link_i;
    logic [7:0]  uflags_i;
    logic        beat_i;
    logic [7:0]  beat_bytes_i;
    logic        blk_done_i, rpt_done_i, upd_done_i, desc_done_i;
    logic        evt_half_o, evt_cplt_o;

    always #10 clk = ~clk;

    dma_evt_gen i_dma_evt_gen (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .desc_start_i(desc_start_i),
        .desc_bytes_i(desc_bytes_i), .desc_rpt_i(desc_rpt_i),
        .desc_first_i(desc_first_i), .link_i(link_i), .uflags_i(uflags_i),
        .beat_i(beat_i), .beat_bytes_i(beat_bytes_i), .blk_done_i(blk_done_i),
        .rpt_done_i(rpt_done_i), .upd_done_i(upd_done_i),
        .desc_done_i(desc_done_i), .evt_half_o(evt_half_o),
        .evt_cplt_o(evt_cplt_o)
    );

    typedef struct {
        int    cyc;
        logic  h;
        logic  c;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    // Monitor: every cycle compares outputs with the queued or idle expectation.
    initial begin
        logic  eh, ec;
        string tg;
        forever begin
            @(posedge clk);
            cyc++;
            #5;
            eh = 1'b0; ec = 1'b0; tg = cur_tag;
            if (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
                eh = sb_q[0].h; ec = sb_q[0].c; tg = sb_q[0].tag;
                void'(sb_q.pop_front());
            end
            n_vec++;
            if (evt_half_o !== eh || evt_cplt_o !== ec) begin
                n_bad++;
                $display("FAIL %s cycle %0d: half/cplt actual %b/%b expected %b/%b",
                         tg, cyc, evt_half_o, evt_cplt_o, eh, ec);
            end
        end
    end

    // Driver: one cycle of strobes, queueing the expected pulse pair.
    task automatic drv(input logic ds, input logic bt, input int bb,
                       input logic bd, input logic rd, input logic ud,
                       input logic dd, input logic eh, input logic ec,
                       input string tag);
        @(negedge clk);
        desc_start_i = ds; beat_i = bt; beat_bytes_i = bb[7:0];
        blk_done_i = bd; rpt_done_i = rd; upd_done_i = ud; desc_done_i = dd;
        if (eh || ec) sb_q.push_back('{cyc + 1, eh, ec, tag});
    endtask

    task automatic start(input logic [1:0] md, input int by, input int rp,
                         input logic fst, input int lk, input int fl,
                         input string tag);
        cur_tag = tag;
        @(negedge clk);
        mode_i = md; desc_bytes_i = by[15:0]; desc_rpt_i = rp[10:0];
        desc_first_i = fst; link_i = lk[13:0]; uflags_i = fl[7:0];
        desc_start_i = 1'b1; beat_i = 1'b0; blk_done_i = 1'b0;
        rpt_done_i = 1'b0; upd_done_i = 1'b0; desc_done_i = 1'b0;
    endtask

    task automatic bt(input int n, input logic bd, input logic rd,
                      input logic eh, input logic ec, input string tag);
        drv(1'b0, 1'b1, n, bd, rd, 1'b0, 1'b0, eh, ec, tag);
    endtask

    task automatic idle();
        drv(1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_i = 2'd0; desc_start_i = 1'b0; desc_bytes_i = '0;
        desc_rpt_i = '0; desc_first_i = 1'b0; link_i = '0; uflags_i = '0;
        beat_i = 1'b0; beat_bytes_i = '0; blk_done_i = 1'b0; rpt_done_i = 1'b0;
        upd_done_i = 1'b0; desc_done_i = 1'b0;
        repeat (4) @(negedge clk);   // R1: outputs checked low throughout
        rst_n = 1'b1;
        idle(); idle();

        // R2: 8-byte block, half after 4 bytes, complete on block end
        start(2'd0, 8, 0, 1'b0, 5, 0, "R2");
        bt(2, 0, 0, 0, 0, "R2"); bt(2, 0, 0, 1, 0, "R2");
        bt(2, 0, 0, 0, 0, "R2"); bt(2, 1, 0, 0, 1, "R2");
        // R2: each block of a repeated set raises its own events
        start(2'd0, 4, 1, 1'b0, 5, 0, "R2");
        bt(2, 0, 0, 1, 0, "R2"); bt(2, 1, 0, 0, 1, "R2");
        bt(2, 0, 0, 1, 0, "R2"); bt(2, 1, 1, 0, 1, "R2");
        // R3: set of 3 x 4 bytes, block ends silent
        start(2'd1, 4, 2, 1'b0, 5, 0, "R3");
        bt(4, 0, 0, 0, 0, "R3"); bt(4, 1, 0, 1, 0, "R3"); bt(4, 1, 1, 0, 1, "R3");
        // R9: odd size 5, single half at the third byte
        start(2'd0, 5, 0, 1'b0, 5, 0, "R9");
        bt(1, 0, 0, 0, 0, "R9"); bt(1, 0, 0, 0, 0, "R9"); bt(1, 0, 0, 1, 0, "R9");
        bt(1, 0, 0, 0, 0, "R9"); bt(1, 1, 0, 0, 1, "R9");
        // R10: one-byte block, half and complete together
        start(2'd0, 1, 0, 1'b0, 5, 0, "R10");
        bt(1, 1, 0, 1, 1, "R10");
        // R4: descriptor of 2 x 6 bytes, complete on descriptor end
        start(2'd2, 6, 1, 1'b0, 5, 0, "R4");
        bt(3, 0, 0, 0, 0, "R4"); bt(3, 1, 0, 1, 0, "R4");
        bt(3, 0, 0, 0, 0, "R4"); bt(3, 1, 1, 0, 0, "R4");
        drv(0, 0, 0, 0, 0, 1, 0, 0, 0, "R4");
        drv(0, 0, 0, 0, 0, 0, 1, 0, 1, "R4");
        // R4: descriptor without data, complete only
        start(2'd2, 0, 0, 1'b0, 5, 0, "R4");
        drv(0, 0, 0, 0, 0, 0, 1, 0, 1, "R4");
        // R7: empty initial transfer under block and set modes
        start(2'd0, 0, 0, 1'b1, 5, 0, "R7");
        drv(0, 0, 0, 1, 0, 0, 0, 0, 0, "R7");
        start(2'd1, 0, 0, 1'b1, 5, 0, "R7");
        drv(0, 0, 0, 1, 1, 0, 0, 0, 0, "R7");
        // R8: empty initial transfer under descriptor mode
        start(2'd2, 0, 0, 1'b1, 5, 0, "R8");
        drv(0, 0, 0, 0, 0, 1, 0, 0, 1, "R8");
        drv(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
        // R6: descriptors with non-zero links stay silent
        for (int k = 1; k <= 3; k++) begin
            start(2'd3, 4, 0, 1'b0, k * 7, 0, "R6");
            bt(2, 0, 0, 0, 0, "R6"); bt(2, 1, 0, 0, 0, "R6");
            drv(0, 0, 0, 0, 0, 1, 1, 0, 0, "R6");
        end
        // R5: zero link with flags set is not last; fully zero is last
        start(2'd3, 4, 0, 1'b0, 0, 3, "R5");
        bt(4, 1, 0, 0, 0, "R5");
        drv(0, 0, 0, 0, 0, 0, 1, 0, 0, "R5");
        start(2'd3, 4, 0, 1'b0, 0, 0, "R5");
        bt(2, 0, 0, 1, 0, "R5"); bt(2, 1, 0, 0, 0, "R5");
        drv(0, 0, 0, 0, 0, 0, 1, 0, 1, "R5");
        // R11: mode change mid-descriptor has no effect
        start(2'd0, 4, 0, 1'b0, 5, 0, "R11");
        idle();
        mode_i = 2'd3;
        bt(2, 0, 0, 1, 0, "R11"); bt(2, 1, 0, 0, 1, "R11");

        idle(); idle(); idle();
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule